// File: doc/BRIEF.md
# Nibble Port Expander Strobe Controller

This block moves one 4-bit value between a host and an external 4-bit port expander. The two share a 4-bit bus on the low half of port 2 and an active-low strobe. The host asks for a transfer by giving an expander port number, an operation and a data nibble. The controller first places a control nibble on the bus and then pulls the strobe low. The falling edge lets the expander latch which port and which operation are meant.

While the strobe is low, the controller either drives the data nibble or releases the bus so that the expander can drive it. A write-type operation completes on the rising edge. A read captures the expander's nibble in the last low cycle. The controller then returns any captured nibble and raises a one-cycle completion pulse. When no transfer runs, the strobe rests high and the bus nibble is released.

The setup, control-hold, strobe-low and data-hold windows are parameters counted in clock cycles. The defaults are 2, 4, 10 and 3.

Top module: `xpd_strobe`

## Requirements
- R1: After reset, `prog_n` is 1, `p2_oe` is 0, `done` is 0 and `busy` is 0.
- R2: The control nibble is `{op[1:0], port[1:0]}`. Bits 1:0 hold the port number and bits 3:2 hold the operation: 00 read, 01 write, 10 OR, 11 AND. It is driven (`p2_oe`=1) for exactly SETUP_CYC (2) cycles with `prog_n` high, starting the cycle after the request is accepted, before the strobe falls.
- R3: The control nibble stays driven and unchanged for the first CTRL_HOLD (4) cycles of the strobe-low window.
- R4: `prog_n` stays low for exactly LOW_CYC (10) consecutive cycles per transfer, and falls once per transfer.
- R5: For operations 01, 10 and 11, the data nibble is driven in the last LOW_CYC-CTRL_HOLD (6) low cycles. It is still driven for DATA_HOLD (3) cycles after the strobe rises, with `prog_n` high.
- R6: For operation 00, the bus is released (`p2_oe`=0) in the last 6 low cycles. `rd_data` becomes the `p2_in` value present in the final low cycle.
- R7: `done` is high for exactly one cycle. For a read, this is the cycle right after the last low cycle. For a write-type operation, it is the cycle right after the last data-hold cycle.
- R8: `busy` is high from the cycle after acceptance until `done`. A request raised while `busy` is high has no effect: the transfer in flight keeps its nibbles and no transfer follows.
- R9: Whenever no transfer is active, `prog_n` is 1 and `p2_oe` is 0.
- R10: `rd_data` holds its value until the next read completes. Write-type transfers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request, taken when not busy |
| req_port | input | 2 | Expander port number |
| req_op | input | 2 | Operation code (00 read, 01 write, 10 OR, 11 AND) |
| req_data | input | 4 | Data nibble for write-type operations |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 4 | Nibble captured by the last read |
| prog_n | output | 1 | Active-low expander strobe |
| p2_oe | output | 1 | Drive enable for the bus nibble |
| p2_out | output | 4 | Bus nibble driven value |
| p2_in | input | 4 | Bus nibble sampled value |

## Verification
The bench drives `p2_in` with the complement of the expected value everywhere except the released part of the low window. A design that samples one cycle early or late therefore returns an inverted nibble. Each transfer is profiled cycle by cycle: setup length, strobe-low length, the point where control changes to data, and the hold tail. An off-by-one counter shows up as a wrong count, and a design that drops the bus too early shows `p2_oe` low during the hold. A second request raised mid-transfer with different fields would corrupt the driven nibbles or start an extra strobe if it were not refused. A write issued after a read must leave `rd_data` untouched.

// File: rtl/xpd_pkg.sv
package xpd_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_CTRL,
        PH_DATA,
        PH_HOLD
    } xpd_phase_t;

    localparam logic [1:0] XOP_READ  = 2'b00;
    localparam logic [1:0] XOP_WRITE = 2'b01;
    localparam logic [1:0] XOP_OR    = 2'b10;
    localparam logic [1:0] XOP_AND   = 2'b11;

endpackage

// File: rtl/xpd_seq.sv
module xpd_seq
    import xpd_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int CTRL_HOLD = 4,
    parameter int LOW_CYC   = 10,
    parameter int DATA_HOLD = 3,
    parameter int NW        = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_port,
    input  logic [1:0]       req_op,
    input  logic [NW-1:0]    req_data,
    input  logic [NW-1:0]    p2_in,
    output xpd_phase_t       phase,
    output logic [NW-1:0]    ctrl_nib,
    output logic [NW-1:0]    wr_nib,
    output logic [NW-1:0]    rd_data,
    output logic             done,
    output logic             busy
);
    localparam int DATA_CYC = LOW_CYC - CTRL_HOLD;
    localparam int SPAN     = SETUP_CYC + LOW_CYC + DATA_HOLD;
    localparam int CW       = $clog2(SPAN + 1);

    typedef struct packed {
        xpd_phase_t    phase;
        logic [CW-1:0] cnt;
        logic [NW-1:0] ctrl;
        logic [NW-1:0] wdata;
        logic [NW-1:0] rdata;
        logic          done;
    } seq_state_t;

    seq_state_t s_d, s_q;
    logic       is_read_q;

    assign is_read_q = (s_q.ctrl[3:2] == XOP_READ);

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    s_d.phase = PH_SETUP;
                    s_d.cnt   = CW'(SETUP_CYC - 1);
                    s_d.ctrl  = NW'({req_op, req_port});
                    s_d.wdata = req_data;
                end
            end
            PH_SETUP: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_CTRL;
                    s_d.cnt   = CW'(CTRL_HOLD - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_CTRL: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_DATA;
                    s_d.cnt   = CW'(DATA_CYC - 1);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_DATA: begin
                if (s_q.cnt == '0) begin
                    if (is_read_q) begin
                        s_d.phase = PH_IDLE;
                        s_d.rdata = p2_in;
                        s_d.done  = 1'b1;
                    end else begin
                        s_d.phase = PH_HOLD;
                        s_d.cnt   = CW'(DATA_HOLD - 1);
                    end
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_HOLD: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_IDLE;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, ctrl: '0, wdata: '0, rdata: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign phase    = s_q.phase;
    assign ctrl_nib = s_q.ctrl;
    assign wr_nib   = s_q.wdata;
    assign rd_data  = s_q.rdata;
    assign done     = s_q.done;
    assign busy     = (s_q.phase != PH_IDLE);
endmodule

// File: rtl/xpd_pads.sv
module xpd_pads
    import xpd_pkg::*;
#(
    parameter int NW = 4
) (
    input  xpd_phase_t    phase,
    input  logic [NW-1:0] ctrl_nib,
    input  logic [NW-1:0] wr_nib,
    output logic          prog_n,
    output logic          p2_oe,
    output logic [NW-1:0] p2_out
);
    logic is_read;
    logic data_slot;

    always_comb begin
        is_read   = (ctrl_nib[3:2] == XOP_READ);
        data_slot = (phase == PH_DATA) || (phase == PH_HOLD);
        prog_n    = !((phase == PH_CTRL) || (phase == PH_DATA));
        p2_oe     = (phase == PH_SETUP) || (phase == PH_CTRL) ||
                    (phase == PH_HOLD)  || ((phase == PH_DATA) && !is_read);
        if (!p2_oe)         p2_out = '0;
        else if (data_slot) p2_out = wr_nib;
        else                p2_out = ctrl_nib;
    end
endmodule

// File: rtl/xpd_strobe.sv
module xpd_strobe
    import xpd_pkg::*;
#(
    parameter int SETUP_CYC = 2,
    parameter int CTRL_HOLD = 4,
    parameter int LOW_CYC   = 10,
    parameter int DATA_HOLD = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [1:0] req_port,
    input  logic [1:0] req_op,
    input  logic [3:0] req_data,
    output logic       busy,
    output logic       done,
    output logic [3:0] rd_data,
    output logic       prog_n,
    output logic       p2_oe,
    output logic [3:0] p2_out,
    input  logic [3:0] p2_in
);
    localparam int NW = 4;

    xpd_phase_t    phase;
    logic [NW-1:0] ctrl_nib;
    logic [NW-1:0] wr_nib;

    xpd_seq #(
        .SETUP_CYC(SETUP_CYC),
        .CTRL_HOLD(CTRL_HOLD),
        .LOW_CYC  (LOW_CYC),
        .DATA_HOLD(DATA_HOLD),
        .NW       (NW)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_port (req_port),
        .req_op   (req_op),
        .req_data (req_data),
        .p2_in    (p2_in),
        .phase    (phase),
        .ctrl_nib (ctrl_nib),
        .wr_nib   (wr_nib),
        .rd_data  (rd_data),
        .done     (done),
        .busy     (busy)
    );

    xpd_pads #(.NW(NW)) u_pads (
        .phase   (phase),
        .ctrl_nib(ctrl_nib),
        .wr_nib  (wr_nib),
        .prog_n  (prog_n),
        .p2_oe   (p2_oe),
        .p2_out  (p2_out)
    );
endmodule

// File: rtl/xpd_strobe_chk.sv
module xpd_strobe_chk #(
    parameter int CTRL_HOLD = 4,
    parameter int LOW_CYC   = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       prog_n,
    input logic       p2_oe,
    input logic [3:0] p2_out
);
    logic [7:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       low_run_q <= '0;
        else if (!prog_n) low_run_q <= low_run_q + 8'd1;
        else              low_run_q <= '0;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (prog_n && !p2_oe)); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

    AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_n) |-> (low_run_q == 8'(LOW_CYC))); // R4

    AST_CTRL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_n && low_run_q > 8'd0 && low_run_q < 8'(CTRL_HOLD)) |-> (p2_oe && $stable(p2_out))); // R3

    AST_SETUP_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_n) |-> (p2_oe && $past(p2_oe))); // R2
endmodule

bind xpd_strobe xpd_strobe_chk #(
    .CTRL_HOLD(CTRL_HOLD),
    .LOW_CYC  (LOW_CYC)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .prog_n(prog_n),
    .p2_oe (p2_oe),
    .p2_out(p2_out)
);

// File: tb/xpd_strobe_test.sv
`timescale 1ns/1ps
module xpd_strobe_test;
    localparam int SETUP_N = 2;
    localparam int HOLD_N  = 4;
    localparam int LOW_N   = 10;
    localparam int TAIL_N  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_port = '0;
    logic [1:0] req_op = '0;
    logic [3:0] req_data = '0;
    logic       busy, done, prog_n, p2_oe;
    logic [3:0] rd_data, p2_out;
    logic [3:0] p2_in = '0;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    xpd_strobe uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
        .req_op(req_op), .req_data(req_data), .busy(busy), .done(done),
        .rd_data(rd_data), .prog_n(prog_n), .p2_oe(p2_oe), .p2_out(p2_out),
        .p2_in(p2_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic [1:0] port, input logic [1:0] op,
                        input logic [3:0] data, input logic [3:0] pin, input bit poke);
        logic [3:0] ctrl;
        bit rd, fin, ok_pre, ok_ctrl, ok_data, ok_hold, ok_busy;
        int pre, low, post, done_at, lowfalls;
        ctrl = {op, port};
        rd = (op == 2'b00);
        fin = 0; ok_pre = 1; ok_ctrl = 1; ok_data = 1; ok_hold = 1; ok_busy = 1;
        pre = 0; low = 0; post = 0; done_at = -1; lowfalls = 0;
        @(negedge clk);
        req_valid = 1'b1; req_port = port; req_op = op; req_data = data;
        p2_in = ~pin;
        @(negedge clk);
        for (int c = 0; c < 60 && !fin; c++) begin
            req_valid = 1'b0;
            if (!prog_n) begin
                if (low == 0) lowfalls++;
                if (post != 0) lowfalls++;
                if (!busy) ok_busy = 0;
                if (low < HOLD_N) begin
                    if (!(p2_oe && p2_out == ctrl)) ok_ctrl = 0;
                end else if (rd) begin
                    if (p2_oe) ok_data = 0;
                end else if (!(p2_oe && p2_out == data)) ok_data = 0;
                p2_in = (low >= HOLD_N) ? pin : ~pin;
                if (poke && low == 2) begin
                    req_valid = 1'b1; req_port = ~port; req_op = ~op; req_data = ~data;
                end
                low++;
            end else if (low == 0) begin
                if (!busy) ok_busy = 0;
                if (!(p2_oe && p2_out == ctrl)) ok_pre = 0;
                pre++;
            end else begin
                p2_in = ~pin;
                if (done) begin
                    done_at = post;
                    fin = 1;
                    if (p2_oe || busy) ok_hold = 0;
                end else if (!rd) begin
                    if (!(p2_oe && p2_out == data && busy)) ok_hold = 0;
                end
                post++;
            end
            if (!fin) @(negedge clk);
        end
        chk(pre == SETUP_N, "R2 setup cycles before strobe", pre, SETUP_N);
        chk(ok_pre, "R2 control nibble {op,port} during setup", p2_out, ctrl);
        chk(ok_ctrl, "R3 control held in first low cycles", 0, 1);
        chk(low == LOW_N && lowfalls == 1, "R4 strobe low width", low, LOW_N);
        if (rd) chk(ok_data, "R6 bus released in read window", 0, 1);
        else    chk(ok_data, "R5 data nibble in low window", 0, 1);
        chk(ok_hold, "R5 data hold after rise / idle at done", 0, 1);
        chk(done_at == (rd ? 0 : TAIL_N), "R7 done timing", done_at, rd ? 0 : TAIL_N);
        chk(ok_busy, "R8 busy through transfer", 0, 1);
        if (rd) chk(rd_data == pin, "R6 read capture", rd_data, pin);
        @(negedge clk);
        chk(!done, "R7 done single cycle", done, 0);
        if (poke) begin
            bit quiet;
            quiet = 1;
            for (int k = 0; k < 6; k++) begin
                if (!prog_n || p2_oe || busy) quiet = 0;
                @(negedge clk);
            end
            chk(quiet, "R8 refused request started nothing", 0, 1);
        end
    endtask

    task automatic t_reset;
        chk(prog_n == 1'b1, "R1 prog_n at reset", prog_n, 1);
        chk(p2_oe == 1'b0 && done == 1'b0 && busy == 1'b0, "R1 oe/done/busy at reset",
            {p2_oe, done, busy}, 0);
    endtask

    task automatic t_idle;
        bit ok;
        ok = 1;
        for (int k = 0; k < 5; k++) begin
            if (!prog_n || p2_oe) ok = 0;
            @(negedge clk);
        end
        chk(ok, "R9 idle strobe high and bus released", {prog_n, p2_oe}, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_idle();
        xfer(2'd0, 2'b00, 4'h0, 4'hA, 0);
        xfer(2'd3, 2'b01, 4'h5, 4'h0, 0);
        chk(rd_data == 4'hA, "R10 rd_data kept after write", rd_data, 4'hA);
        xfer(2'd1, 2'b10, 4'hC, 4'h0, 0);
        xfer(2'd2, 2'b11, 4'h3, 4'h0, 1);
        chk(rd_data == 4'hA, "R10 rd_data kept after OR/AND", rd_data, 4'hA);
        xfer(2'd2, 2'b00, 4'h0, 4'h6, 1);
        xfer(2'd1, 2'b00, 4'h0, 4'hF, 0);
        t_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule